// File: doc/BRIEF.md
# Multi-Port Receive Poller with Class Priority and Weighted Round-Robin

This block is the cell-layer side of a shared receive bus to which up to thirty-one line ports are attached. It drives a 5-bit port address to poll each enabled port in turn. A port answers on a single cell-available line in the cycle after it was addressed, and the block keeps one ready bit per port from these answers. When no cell is being read, the block picks one ready port. It puts that port's address on the bus for one cycle and then holds the active-low read enable low for exactly one cell. It captures every word of the cell and passes it on with the number of the port it came from.

Each port is placed in one of four priority classes. Class 0 wins over class 1, class 1 over class 2, and class 2 over class 3. Inside a class, ports take turns in ascending index order. Each port also has a weight, which sets how many cells in a row it may take before its turn passes on. Polling continues while a cell is being read, so the ready picture is current when the cell ends. Once a read has started, the enable is never paused. The cell length follows the bus width: 27 words at 16 bits, or 53 words at 8 bits.

Top module: `mphy_rx_poller`

## Requirements
- R1: Only ports enabled in `portActive` are polled, in ascending index order, wrapping around. In a cycle in which nothing is polled or selected, `phyAddr` carries the null address 31. A disabled port is never polled and never selected.
- R2: The `rxClav` value seen in the cycle after a port was polled sets or clears that port's ready bit. A port becomes eligible only through such a poll result.
- R3: If ready ports exist in more than one class, the port chosen comes from the lowest-numbered class. Class is a 2-bit field per port, at bits [2i+1:2i] of `portClass`.
- R4: Within a class, the choice is the first ready port at or after that class's turn pointer, searching in ascending index order and wrapping. A port may take as many cells in a row as its 4-bit weight, at bits [4i+3:4i] of `portWeight`. When that count is used up, or when another port is chosen, the pointer moves to the index after the chosen port. A weight of 0 behaves as 1. After reset, every pointer is at index 0.
- R5: A selection takes one cycle, with `phyAddr` equal to the chosen port and `rxEnb_n` high. `rxEnb_n` is then low for exactly the cell length, with no gap.
- R6: A word on `rxData` in a cycle with `rxEnb_n` low appears on `outData` one cycle later, with `outValid` high and `outPort` equal to the selected port. `outStart` is high on the first word of each cell only.
- R7: If `rxSoc` is low on the first word of a cell, `framingErr` pulses high in the same cycle as that word's `outStart`. Otherwise `framingErr` stays low.
- R8: A port's ready bit is cleared in the cycle it is selected. This clearing wins over a poll result that arrives in the same cycle. The bit is set again only by a later poll.
- R9: While reset is held, `rxEnb_n` is high and `outValid` and `framingErr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| portActive | input | NPORT | Per-port enable |
| portClass | input | 2*NPORT | Per-port priority class, 0 highest |
| portWeight | input | 4*NPORT | Per-port weight for consecutive cells |
| phyAddr | output | 5 | Poll or select address; 31 means null |
| rxEnb_n | output | 1 | Active-low read enable |
| rxClav | input | 1 | Cell-available answer for the previous cycle's address |
| rxData | input | DATA_W | Receive data word |
| rxSoc | input | 1 | Start-of-cell marker |
| outValid | output | 1 | Output word valid |
| outData | output | DATA_W | Captured word |
| outPort | output | 5 | Source port of the word |
| outStart | output | 1 | First word of a cell |
| framingErr | output | 1 | First word lacked start-of-cell |

## Verification
The grant order is tried with five kinds of pattern: all ports in one class with weight 1, one class with mixed weights including 0, one port in a high class that is always ready above lower classes, lower classes alone, and a sparse set of enabled ports with the cell-available line high everywhere. Together these tell plain rotation from weighted runs, strict priority from sharing, and real polling from leaked answers of disabled ports. Every word is compared with a tag that the model line port builds from the latched address and word index. This exposes off-by-one capture, gaps and wrong tags. One run drops the cell-available answer right after a grant, to show that a stale ready bit cannot cause a second cell. Another run leaves out the start-of-cell marker, to show the framing pulse.

// File: rtl/mphy_rx_pkg.sv
package mphy_rx_pkg;
  localparam int ADDR_W   = 5;
  localparam int NCLASS   = 4;
  localparam int CLASS_W  = 2;
  localparam int WEIGHT_W = 4;
  localparam logic [ADDR_W-1:0] NULL_ADDR = '1;

  typedef enum logic {ST_IDLE, ST_XFER} rx_state_e;

  typedef struct packed {
    logic              capture;
    logic              firstWord;
    logic [ADDR_W-1:0] port;
  } rx_strobe_t;
endpackage

// File: rtl/mphy_rx_arbiter.sv
module mphy_rx_arbiter
  import mphy_rx_pkg::*;
#(
  parameter int NPORT  = 8,
  parameter int PIDX_W = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NPORT-1:0]           req,
  input  logic [CLASS_W*NPORT-1:0]   portClass,
  input  logic [WEIGHT_W*NPORT-1:0]  portWeight,
  input  logic                       take,
  output logic                       grantValid,
  output logic [PIDX_W-1:0]          grantIdx
);
  logic [NCLASS-1:0][PIDX_W-1:0] ptrQ;
  logic [NCLASS-1:0][PIDX_W-1:0] pick;
  logic [NCLASS-1:0]             hit;
  logic [CLASS_W-1:0]            winClass;
  logic                          higherReq;

  always_comb begin
    for (int c = 0; c < NCLASS; c++) begin
      hit[c]  = 1'b0;
      pick[c] = ptrQ[c];
      for (int k = NPORT - 1; k >= 0; k--) begin
        int idx;
        idx = (int'(ptrQ[c]) + k) % NPORT;
        if (req[PIDX_W'(idx)] && portClass[CLASS_W*idx +: CLASS_W] == CLASS_W'(c)) begin
          hit[c]  = 1'b1;
          pick[c] = PIDX_W'(idx);
        end
      end
    end
    winClass = '0;
    for (int c = NCLASS - 1; c >= 0; c--) begin
      if (hit[c]) winClass = CLASS_W'(c);
    end
    grantValid = |hit;
    grantIdx   = pick[winClass];
  end

  for (genvar c = 0; c < NCLASS; c++) begin : g_class
    logic [PIDX_W-1:0]   ptrR;
    logic [WEIGHT_W-1:0] usedR;
    logic [WEIGHT_W-1:0] wEff;
    logic [WEIGHT_W:0]   nextUsed;

    always_comb begin
      wEff = portWeight[WEIGHT_W*pick[c] +: WEIGHT_W];
      if (wEff == '0) wEff = WEIGHT_W'(1);
      nextUsed = ((pick[c] == ptrR) ? {1'b0, usedR} : '0) + (WEIGHT_W+1)'(1);
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ptrR  <= '0;
        usedR <= '0;
      end else if (take && winClass == CLASS_W'(c)) begin
        if (nextUsed >= {1'b0, wEff}) begin
          ptrR  <= PIDX_W'((int'(pick[c]) + 1) % NPORT);
          usedR <= '0;
        end else begin
          ptrR  <= pick[c];
          usedR <= nextUsed[WEIGHT_W-1:0];
        end
      end
    end

    assign ptrQ[c] = ptrR;
  end

  // Independent scan: any requester in a class above the winner.
  always_comb begin
    higherReq = 1'b0;
    for (int i = 0; i < NPORT; i++) begin
      if (req[i] && portClass[CLASS_W*i +: CLASS_W] < winClass) higherReq = 1'b1;
    end
  end

  assert_class_prio_R3: assert property (@(posedge clk) disable iff (!rst_n)
    grantValid |-> !higherReq);

  assert_grant_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> req[grantIdx]);
endmodule

// File: rtl/mphy_rx_ctrl.sv
module mphy_rx_ctrl
  import mphy_rx_pkg::*;
#(
  parameter int NPORT      = 8,
  parameter int PIDX_W     = 3,
  parameter int CELL_WORDS = 27
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPORT-1:0]  portActive,
  input  logic              rxClav,
  input  logic              grantValid,
  input  logic [PIDX_W-1:0] grantIdx,
  output logic              take,
  output logic [NPORT-1:0]  readyQ,
  output logic [ADDR_W-1:0] phyAddr,
  output logic              rxEnb_n,
  output rx_strobe_t        strobe
);
  localparam int CNT_W = $clog2(CELL_WORDS);

  rx_state_e         state;
  logic [CNT_W-1:0]  wordCnt;
  logic [PIDX_W-1:0] curPort;
  logic [PIDX_W-1:0] pollIdx;
  logic [PIDX_W-1:0] nextPoll;
  logic [PIDX_W-1:0] lastIdx;
  logic              lastValid;
  logic              selectNow;
  logic              pollHere;
  logic [NPORT-1:0]  readyN;
  logic [CNT_W:0]    lowRun;

  always_comb begin
    selectNow = (state == ST_IDLE) && grantValid;
    pollHere  = !selectNow && portActive[pollIdx];
    nextPoll  = pollIdx;
    for (int k = NPORT; k >= 1; k--) begin
      int idx;
      idx = (int'(pollIdx) + k) % NPORT;
      if (portActive[PIDX_W'(idx)]) nextPoll = PIDX_W'(idx);
    end
    if (selectNow)     phyAddr = ADDR_W'(grantIdx);
    else if (pollHere) phyAddr = ADDR_W'(pollIdx);
    else               phyAddr = NULL_ADDR;
    rxEnb_n          = (state != ST_XFER);
    take             = selectNow;
    strobe.capture   = (state == ST_XFER);
    strobe.firstWord = (wordCnt == '0);
    strobe.port      = ADDR_W'(curPort);
    readyN = readyQ;
    if (lastValid) readyN[lastIdx] = rxClav;
    if (selectNow) readyN[grantIdx] = 1'b0;
    readyN = readyN & portActive;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      wordCnt   <= '0;
      curPort   <= '0;
      pollIdx   <= '0;
      lastIdx   <= '0;
      lastValid <= 1'b0;
      readyQ    <= '0;
    end else begin
      readyQ    <= readyN;
      lastValid <= pollHere;
      lastIdx   <= pollIdx;
      if (!selectNow) pollIdx <= nextPoll;
      case (state)
        ST_IDLE: if (grantValid) begin
          state   <= ST_XFER;
          wordCnt <= '0;
          curPort <= grantIdx;
        end
        ST_XFER: begin
          if (wordCnt == CNT_W'(CELL_WORDS - 1)) state <= ST_IDLE;
          wordCnt <= wordCnt + CNT_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Length of the current low run of the enable, kept apart from wordCnt.
  always_ff @(posedge clk) begin
    if (!rst_n)        lowRun <= '0;
    else if (!rxEnb_n) lowRun <= lowRun + (CNT_W+1)'(1);
    else               lowRun <= '0;
  end

  assert_enb_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxEnb_n) |-> lowRun == (CNT_W+1)'(CELL_WORDS));

  assert_select_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rxEnb_n) |-> ($past(phyAddr) == ADDR_W'(curPort)));

  assert_ready_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !readyQ[$past(grantIdx)]);

  assert_poll_active_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (phyAddr != NULL_ADDR) |-> (phyAddr < ADDR_W'(NPORT)) && portActive[phyAddr[PIDX_W-1:0]]);
endmodule

// File: rtl/mphy_rx_datapath.sv
module mphy_rx_datapath
  import mphy_rx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rx_strobe_t        strobe,
  input  logic [DATA_W-1:0] rxData,
  input  logic              rxSoc,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic [ADDR_W-1:0] outPort,
  output logic              outStart,
  output logic              framingErr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid   <= 1'b0;
      outData    <= '0;
      outPort    <= '0;
      outStart   <= 1'b0;
      framingErr <= 1'b0;
    end else begin
      outValid   <= strobe.capture;
      outStart   <= strobe.capture && strobe.firstWord;
      framingErr <= strobe.capture && strobe.firstWord && !rxSoc;
      if (strobe.capture) begin
        outData <= rxData;
        outPort <= strobe.port;
      end
    end
  end

  assert_framing_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    framingErr |-> outStart && outValid);

  assert_port_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outStart && $past(outValid)) |-> outPort == $past(outPort));
endmodule

// File: rtl/mphy_rx_poller.sv
module mphy_rx_poller
  import mphy_rx_pkg::*;
#(
  parameter int NPORT  = 8,
  parameter int DATA_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NPORT-1:0]          portActive,
  input  logic [CLASS_W*NPORT-1:0]  portClass,
  input  logic [WEIGHT_W*NPORT-1:0] portWeight,
  output logic [ADDR_W-1:0]         phyAddr,
  output logic                      rxEnb_n,
  input  logic                      rxClav,
  input  logic [DATA_W-1:0]         rxData,
  input  logic                      rxSoc,
  output logic                      outValid,
  output logic [DATA_W-1:0]         outData,
  output logic [ADDR_W-1:0]         outPort,
  output logic                      outStart,
  output logic                      framingErr
);
  localparam int PIDX_W     = (NPORT > 1) ? $clog2(NPORT) : 1;
  localparam int CELL_WORDS = (DATA_W == 8) ? 53 : 27;

  logic              take;
  logic              grantValid;
  logic [PIDX_W-1:0] grantIdx;
  logic [NPORT-1:0]  readyQ;
  rx_strobe_t        strobe;

  initial begin
    assert (NPORT >= 1 && NPORT <= 31) else $error("NPORT out of range");
  end

  mphy_rx_arbiter #(.NPORT(NPORT), .PIDX_W(PIDX_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(readyQ), .portClass(portClass),
    .portWeight(portWeight), .take(take), .grantValid(grantValid), .grantIdx(grantIdx));

  mphy_rx_ctrl #(.NPORT(NPORT), .PIDX_W(PIDX_W), .CELL_WORDS(CELL_WORDS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .portActive(portActive), .rxClav(rxClav),
    .grantValid(grantValid), .grantIdx(grantIdx), .take(take), .readyQ(readyQ),
    .phyAddr(phyAddr), .rxEnb_n(rxEnb_n), .strobe(strobe));

  mphy_rx_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .rxData(rxData), .rxSoc(rxSoc),
    .outValid(outValid), .outData(outData), .outPort(outPort),
    .outStart(outStart), .framingErr(framingErr));
endmodule

// File: tb/mphy_rx_poller_test.sv
module mphy_rx_poller_test;
  localparam int NPORT = 8;
  localparam int CELL  = 27;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NPORT-1:0]   portActive = '0;
  logic [2*NPORT-1:0] portClass = '0;
  logic [4*NPORT-1:0] portWeight = '0;
  logic [4:0]  phyAddr;
  logic        rxEnb_n, rxClav, rxSoc;
  logic [15:0] rxData;
  logic        outValid, outStart, framingErr;
  logic [15:0] outData;
  logic [4:0]  outPort;

  always #4 clk = ~clk;

  mphy_rx_poller #(.NPORT(NPORT), .DATA_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .portActive(portActive), .portClass(portClass),
    .portWeight(portWeight), .phyAddr(phyAddr), .rxEnb_n(rxEnb_n), .rxClav(rxClav),
    .rxData(rxData), .rxSoc(rxSoc), .outValid(outValid), .outData(outData),
    .outPort(outPort), .outStart(outStart), .framingErr(framingErr));

  // Line port model: answers for last cycle's address, serves the latched port.
  logic [NPORT-1:0] clavMask = '0;
  logic       socBreak = 1'b0;
  logic [4:0] addrD = 5'h1f;
  logic [4:0] selAddr = '0;
  logic [7:0] wIdx = '0;
  always @(posedge clk) begin
    addrD <= phyAddr;
    if (rxEnb_n) begin selAddr <= phyAddr; wIdx <= '0; end
    else wIdx <= wIdx + 8'd1;
  end
  assign rxClav = (addrD < 5'd8) && clavMask[addrD[2:0]];
  assign rxData = {3'b0, selAddr, wIdx};
  assign rxSoc  = (wIdx == 8'd0) && !socBreak;

  int nChecks = 0, nFail = 0, cyc = 0;
  int cfgClass[NPORT];
  int cfgWeight[NPORT];
  int mPtr[4], mUsed[4];
  bit firstDone, monOn = 0, chkOrder, inCell;
  int cells, wExp, lowRun;
  logic [4:0] curP, prevPoll;
  bit prevPollV;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int modelPick(logic [NPORT-1:0] rdy);
    for (int c = 0; c < 4; c++) begin
      for (int k = 0; k < NPORT; k++) begin
        int idx = (mPtr[c] + k) % NPORT;
        if (rdy[idx] && cfgClass[idx] == c) begin
          int w = (cfgWeight[idx] == 0) ? 1 : cfgWeight[idx];
          int n = ((idx == mPtr[c]) ? mUsed[c] : 0) + 1;
          if (n >= w) begin mPtr[c] = (idx + 1) % NPORT; mUsed[c] = 0; end
          else begin mPtr[c] = idx; mUsed[c] = n; end
          return idx;
        end
      end
    end
    return -1;
  endfunction

  always @(negedge clk) if (monOn) begin
    if (outValid) begin
      if (outStart) begin
        if (inCell) check(0, "R5 cell cut short", wExp, CELL);
        cells++;
        wExp = 0;
        curP = outPort;
        if (chkOrder) begin
          logic [NPORT-1:0] r;
          int e;
          r = clavMask & portActive;
          if (!firstDone) r = r & (~r + 1'b1);
          firstDone = 1;
          e = modelPick(r);
          check(int'(outPort) == e, "R2 R3 R4 grant order", outPort, e);
        end
      end
      check(outData == {3'b0, curP, 8'(wExp)}, "R6 word tag", outData, {3'b0, curP, 8'(wExp)});
      check(outStart == (wExp == 0), "R6 start flag", outStart, wExp == 0);
      check(framingErr == ((wExp == 0) && socBreak), "R7 framing", framingErr, (wExp == 0) && socBreak);
      wExp++;
      inCell = (wExp < CELL);
    end else if (inCell) begin
      check(0, "R5 gap in cell", wExp, CELL);
      inCell = 0;
    end
    if (phyAddr != 5'h1f)
      check(phyAddr < 5'd8 && portActive[phyAddr[2:0]], "R1 address of disabled port", phyAddr, 31);
    if (!rxEnb_n) begin
      lowRun++;
      if (prevPollV) begin
        int e = prevPoll;
        for (int k = NPORT; k >= 1; k--)
          if (portActive[(prevPoll + k) % NPORT]) e = (prevPoll + k) % NPORT;
        check(int'(phyAddr) == e, "R1 poll order", phyAddr, e);
      end
      prevPoll = phyAddr;
      prevPollV = 1;
    end else begin
      if (lowRun > 0) check(lowRun == CELL, "R5 enable length", lowRun, CELL);
      lowRun = 0;
      prevPollV = 0;
    end
  end

  task automatic startRun(input logic [NPORT-1:0] act, input logic [NPORT-1:0] clav,
                          input bit sb, input bit order);
    monOn = 0;
    rst_n = 1'b0;
    for (int i = 0; i < NPORT; i++) begin
      portClass[2*i +: 2]  = 2'(cfgClass[i]);
      portWeight[4*i +: 4] = 4'(cfgWeight[i]);
    end
    portActive = act; clavMask = clav; socBreak = sb; chkOrder = order;
    for (int c = 0; c < 4; c++) begin mPtr[c] = 0; mUsed[c] = 0; end
    firstDone = 0; cells = 0; inCell = 0; prevPollV = 0; lowRun = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(rxEnb_n == 1'b1, "R9 enable idle in reset", rxEnb_n, 1);
    check(outValid == 1'b0, "R9 no output in reset", outValid, 0);
    check(framingErr == 1'b0, "R9 no framing flag in reset", framingErr, 0);
    rst_n = 1'b1;
    monOn = 1;
  endtask

  task automatic waitCells(input int n);
    int t = 0;
    while (cells < n && t < 4000) begin @(negedge clk); t++; end
    check(cells >= n, "R5 cells delivered", cells, n);
    t = 0;
    while (inCell && t < 100) begin @(negedge clk); t++; end
    monOn = 0;
  endtask

  task automatic setCfg(input int cls, input int w);
    for (int i = 0; i < NPORT; i++) begin cfgClass[i] = cls; cfgWeight[i] = w; end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nChecks++; nFail++;
      $display("FAIL R5 watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    // Plain rotation: one class, unit weights.
    setCfg(1, 1);
    startRun(8'hff, 8'hff, 0, 1); waitCells(18);
    // Mixed weights including 0 in one class.
    setCfg(2, 1);
    cfgWeight[0] = 3; cfgWeight[2] = 2; cfgWeight[4] = 4; cfgWeight[5] = 0;
    startRun(8'h3f, 8'hff, 0, 1); waitCells(24);
    // Strict priority: port 5 in class 0 starves the rest.
    setCfg(3, 1);
    cfgClass[5] = 0; cfgClass[1] = 1; cfgClass[3] = 1; cfgWeight[3] = 2;
    startRun(8'h6a, 8'hff, 0, 1); waitCells(10);
    // Lower classes alone: class 1 beats class 3.
    startRun(8'h6a, 8'h4a, 0, 1); waitCells(14);
    // Sparse enabled set with answers on every address.
    setCfg(0, 2);
    cfgClass[4] = 1;
    startRun(8'h12, 8'hff, 0, 1); waitCells(10);
    // Missing start-of-cell marker.
    setCfg(0, 1);
    startRun(8'h81, 8'h81, 1, 1); waitCells(6);
    // Stale ready bit must not cause a second cell (R8).
    setCfg(0, 1);
    startRun(8'h04, 8'h04, 0, 0);
    begin
      int t = 0;
      while (rxEnb_n && t < 200) begin @(negedge clk); t++; end
      clavMask = '0;
      repeat (150) @(negedge clk);
      check(cells == 1, "R8 no second cell without new poll", cells, 1);
      clavMask = 8'h04;
      repeat (80) @(negedge clk);
      check(cells >= 2, "R8 fresh poll re-arms port", cells, 2);
    end
    monOn = 0;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule